// File: doc/BRIEF.md
# Serial Sampling-Converter Frame Engine

This block is the digital face of a 12-bit sampling converter with a serial output, modelled inside a fast system clock domain. A host frames each transfer with an active-low select line and supplies a slow serial clock. The moment the select line falls, the block latches a 12-bit parallel word (standing in for the converter's result), switches its serial data pin out of high impedance and puts the track/hold status into hold.

The word goes out as a 16-bit frame: four zero bits lead, then the 12 result bits, most significant first, in plain unsigned binary. The first zero is presented as soon as select falls. Every later bit is advanced on a falling edge of the serial clock. The 16th falling edge ends the frame: the pin is released and a one-cycle completion pulse is raised. Tracking resumes on the first serial-clock rise after the 13th fall. If select returns high before 16 falls, the frame is abandoned and the pin is released at once.

Both host inputs are synchronised into the system clock and then edge-detected. The serial clock must run at no more than a quarter of the system clock rate. A separate output-enable stands for the tri-state control. A running count of falls since select fell is exported for the power-management logic next to this block.

Top module: `serial_adc_framer`

## Requirements
- R1: After reset, out_en is 0, tracking is 1, fall_count is 0 and frame_done is 0.
- R2: A falling edge on sel_n latches sample_in, sets out_en to 1, fall_count to 0, tracking to 0, and presents a 0 on sdata.
- R3: The frame bit presented after k serial-clock falls (k = 0..15) is bit 15-k of {4'b0000, sample}, so bits 0..3 of the frame are zero and the sample follows MSB first.
- R4: While a frame is active and sel_n is low, each serial-clock fall increments fall_count by exactly one and advances sdata by one bit.
- R5: The 16th fall sets out_en to 0 and fall_count to 16 and raises frame_done for exactly one system clock. Further falls with sel_n still low change nothing.
- R6: tracking stays 0 through the 13th fall and becomes 1 on the next serial-clock rise.
- R7: A rise of sel_n before the 16th fall sets out_en to 0 and tracking to 1, keeps fall_count, and produces no frame_done.
- R8: Changes on sample_in after the sel_n fall do not alter the frame being shifted out.
- R9: If a sel_n rise and a serial-clock fall are detected in the same system clock, the abort wins: fall_count does not advance and no frame_done is produced.
- R10: Serial-clock activity while sel_n is high changes neither out_en nor fall_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Asynchronous active-low frame select from host |
| ser_clk | input | 1 | Asynchronous serial clock from host |
| sample_in | input | 12 | Parallel conversion word, latched on the select fall |
| sdata | output | 1 | Serial data bit (0 while released) |
| out_en | output | 1 | 1 when sdata is driven, 0 for high impedance |
| tracking | output | 1 | 1 = track, 0 = hold |
| fall_count | output | 5 | Serial-clock falls since select fell |
| frame_done | output | 1 | One-cycle pulse on normal frame completion |

## Verification
The select rise (abort) and a serial-clock fall (advance) can be detected in the same system clock. The bench provokes this by changing both host inputs together after the 15th fall, so they travel through identical synchronisers and land in the same cycle. It then judges the outcome at the ports: out_en must be 0, fall_count must still read 15, and the frame-completion counter must not have moved.

// File: rtl/sadc_pkg.sv
// Shared types for the serial converter frame engine.
// Assumes: included before any module of the block.
package sadc_pkg;

    // Frame controller state: waiting for select, or shifting a frame.
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_XFER = 1'b1
    } frame_state_t;

endpackage

// File: rtl/sadc_sync_edge.sv
// Synchroniser plus edge detector for one asynchronous host line.
// Assumes: STAGES >= 2; the input holds each level for at least two clocks.
// Outputs are valid STAGES clocks after an input change; edges last one cycle.
module sadc_sync_edge #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the input through the flop chain and keep last synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE}};
            prev  <= IDLE;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    // Derive level and one-cycle edge strobes.
    always_comb begin
        level = chain[STAGES-1];
        rise  = level & ~prev;
        fall  = ~level & prev;
    end

endmodule

// File: rtl/sadc_frame_ctrl.sv
// Frame sequencer: counts serial-clock falls, owns output enable,
// track/hold status and the completion pulse.
// Assumes: edge strobes are mutually exclusive per line and one cycle wide.
// An abort (select rise) takes priority over a simultaneous fall.
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int TRACK_AFTER = 13,
    parameter int CNT_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sc_fall,
    input  logic             sc_rise,
    output logic             load,
    output logic             shift,
    output logic             oe,
    output logic             track,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] ARM_INDEX = CNT_W'(TRACK_AFTER - 1);

    frame_state_t state;
    logic         arm;
    logic         advance;

    // Qualify a serial-clock fall as a frame step.
    always_comb begin
        advance = (state == FS_XFER) && sc_fall && !cs_lvl && !cs_rise;
        load    = cs_fall;
        shift   = advance && (count != LAST_IDX);
    end

    // Sequence the frame: start, step, finish, abort and track release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            count <= '0;
            oe    <= 1'b0;
            track <= 1'b1;
            done  <= 1'b0;
            arm   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cs_fall) begin
                state <= FS_XFER;
                count <= '0;
                oe    <= 1'b1;
                track <= 1'b0;
                arm   <= 1'b0;
            end else if (cs_rise) begin
                if (state == FS_XFER) begin
                    state <= FS_IDLE;
                    oe    <= 1'b0;
                    track <= 1'b1;
                end
            end else begin
                if (advance) begin
                    count <= count + 1'b1;
                    if (count >= ARM_INDEX) begin
                        arm <= 1'b1;
                    end
                    if (count == LAST_IDX) begin
                        state <= FS_IDLE;
                        oe    <= 1'b0;
                        done  <= 1'b1;
                    end
                end
                if (sc_rise && arm && !track) begin
                    track <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sadc_shifter.sv
// Frame shift register: loads zeros-then-sample and moves one bit per step.
// Assumes: load and shift never assert together.
module sadc_shifter #(
    parameter int RES_BITS   = 12,
    parameter int LEAD_ZEROS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [RES_BITS-1:0] word_in,
    output logic                bit_out
);

    localparam int FRAME_BITS = RES_BITS + LEAD_ZEROS;

    logic [FRAME_BITS-1:0] sh;

    // Load a fresh frame or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= {{LEAD_ZEROS{1'b0}}, word_in};
        end else if (shift) begin
            sh <= {sh[FRAME_BITS-2:0], 1'b0};
        end
    end

    assign bit_out = sh[FRAME_BITS-1];

endmodule

// File: rtl/serial_adc_framer.sv
// Top of the serial converter frame engine.
// Assumes: ser_clk at most a quarter of clk; sel_n idles high.
// Host edges are seen SYNC_STAGES+1 clocks after the pins move.
module serial_adc_framer #(
    parameter int RES_BITS    = 12,
    parameter int LEAD_ZEROS  = 4,
    parameter int TRACK_AFTER = 13,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_BITS = RES_BITS + LEAD_ZEROS,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                ser_clk,
    input  logic [RES_BITS-1:0] sample_in,
    output logic                sdata,
    output logic                out_en,
    output logic                tracking,
    output logic [CNT_W-1:0]    fall_count,
    output logic                frame_done
);

    logic cs_lvl, cs_rise, cs_fall;
    logic sc_lvl, sc_rise, sc_fall;
    logic load, shift, bit_q;

    sadc_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sel_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    sadc_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sc_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk),
        .level(sc_lvl), .rise(sc_rise), .fall(sc_fall)
    );

    sadc_frame_ctrl #(
        .FRAME_BITS(FRAME_BITS), .TRACK_AFTER(TRACK_AFTER), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(cs_lvl), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sc_fall(sc_fall), .sc_rise(sc_rise),
        .load(load), .shift(shift),
        .oe(out_en), .track(tracking), .count(fall_count), .done(frame_done)
    );

    sadc_shifter #(.RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .word_in(sample_in), .bit_out(bit_q)
    );

    // Drive data only while enabled; released pin reads 0.
    always_comb begin
        sdata = out_en & bit_q;
    end

endmodule

// File: rtl/sadc_framer_chk.sv
// Property checker for the frame engine, attached by bind below.
module sadc_framer_chk #(
    parameter int FRAME_BITS  = 16,
    parameter int LEAD_ZEROS  = 4,
    parameter int TRACK_AFTER = 13,
    parameter int CNT_W       = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_lvl,
    input logic             cs_fall,
    input logic             cs_rise,
    input logic             sc_fall,
    input logic             sdata,
    input logic             out_en,
    input logic             tracking,
    input logic [CNT_W-1:0] fall_count,
    input logic             frame_done
);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> out_en && fall_count == '0 && !tracking);

    p_lead_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && fall_count < CNT_W'(LEAD_ZEROS)) |-> !sdata);

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && sc_fall && !cs_lvl && !cs_rise) |=>
            fall_count == $past(fall_count) + 1'b1);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && sc_fall && !cs_lvl && fall_count == CNT_W'(FRAME_BITS - 1))
            |=> !out_en && frame_done);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tracking) |-> (fall_count >= CNT_W'(TRACK_AFTER) || !out_en));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && out_en) |=> !out_en && !frame_done && tracking);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !cs_fall) |=> !out_en);

endmodule

bind serial_adc_framer sadc_framer_chk #(
    .FRAME_BITS(FRAME_BITS), .LEAD_ZEROS(LEAD_ZEROS),
    .TRACK_AFTER(TRACK_AFTER), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sc_fall(sc_fall), .sdata(sdata), .out_en(out_en),
    .tracking(tracking), .fall_count(fall_count), .frame_done(frame_done)
);

// File: tb/tb_serial_adc_framer.sv
module tb_serial_adc_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic [11:0] sample_in = '0;
    logic        sdata, out_en, tracking, frame_done;
    logic [4:0]  fall_count;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    serial_adc_framer dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .sample_in(sample_in), .sdata(sdata), .out_en(out_en),
        .tracking(tracking), .fall_count(fall_count), .frame_done(frame_done)
    );

    always @(posedge clk) if (rst_n && frame_done) done_cnt <= done_cnt + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sc_down(); ser_clk = 1'b0; settle(); endtask
    task automatic sc_up();   ser_clk = 1'b1; settle(); endtask

    task automatic t_reset();
        check("R1", "out_en", out_en, 0);
        check("R1", "tracking", tracking, 1);
        check("R1", "fall_count", fall_count, 0);
        check("R1", "done pulses", done_cnt, 0);
    endtask

    task automatic t_frame(input logic [11:0] s, input bit scramble);
        logic [15:0] fr;
        int d0;
        fr = {4'b0000, s};
        d0 = done_cnt;
        sample_in = s;
        sel_n = 1'b0; settle();
        check("R2", "out_en after select", out_en, 1);
        check("R2", "first bit", sdata, 0);
        check("R2", "count after select", fall_count, 0);
        check("R2", "hold after select", tracking, 0);
        if (scramble) sample_in = ~s;  // R8: must not reach the frame
        for (int k = 1; k <= 16; k++) begin
            sc_down();
            check("R4", "fall_count", fall_count, k);
            if (k < 16) begin
                check(scramble ? "R8" : "R3", "sdata bit", sdata, fr[15-k]);
                check("R4", "out_en mid frame", out_en, 1);
            end
            if (k == 13) check("R6", "hold until rise", tracking, 0);
            sc_up();
            if (k >= 13) check("R6", "track after rise", tracking, 1);
            else check("R6", "still hold", tracking, 0);
        end
        check("R5", "released", out_en, 0);
        check("R5", "one done pulse", done_cnt, d0 + 1);
        sc_down(); sc_up();
        check("R5", "extra fall count", fall_count, 16);
        check("R5", "extra fall oe", out_en, 0);
        check("R5", "no second done", done_cnt, d0 + 1);
        sel_n = 1'b1; settle();
    endtask

    task automatic t_abort(input int n);
        int d0;
        d0 = done_cnt;
        sample_in = 12'h3C3;
        sel_n = 1'b0; settle();
        for (int k = 0; k < n; k++) begin sc_down(); sc_up(); end
        sel_n = 1'b1; settle();
        check("R7", "abort released", out_en, 0);
        check("R7", "abort tracking", tracking, 1);
        check("R7", "abort count kept", fall_count, n);
        check("R7", "abort no done", done_cnt, d0);
    endtask

    task automatic t_same_cycle();
        int d0;
        d0 = done_cnt;
        sel_n = 1'b0; settle();
        for (int k = 0; k < 15; k++) begin sc_down(); sc_up(); end
        check("R9", "count before clash", fall_count, 15);
        @(negedge clk);
        sel_n = 1'b1;
        ser_clk = 1'b0;
        settle();
        check("R9", "clash released", out_en, 0);
        check("R9", "clash count held", fall_count, 15);
        check("R9", "clash no done", done_cnt, d0);
        sc_up();
    endtask

    task automatic t_idle_clock();
        int c0;
        c0 = fall_count;
        for (int k = 0; k < 3; k++) begin sc_down(); sc_up(); end
        check("R10", "idle count", fall_count, c0);
        check("R10", "idle oe", out_en, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_frame(12'hA5C, 1'b0);
        t_frame(12'hFFF, 1'b0);
        t_frame(12'h001, 1'b1);
        t_abort(5);
        t_abort(14);
        t_same_cycle();
        t_idle_clock();
        t_frame(12'h800, 1'b0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule